// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable slave model of a 64-word by 16-bit serial EEPROM on a three-wire bus (select, shift clock, serial data in, plus a serial data out). It runs from a fast system clock. All bus inputs pass through two-flop synchronizers, and the block finds shift-clock edges by comparing the synchronized level with its previous value. A host opens a frame by raising select. The host then clocks in a start bit, a two-bit operation code and a six-bit word address, followed by a 16-bit data word when the operation needs one.

The block supports these operations: word read, word write, word erase, whole-array erase, whole-array write, programming enable and programming disable. A programming-enable latch gates every operation that changes the array. Each accepted change starts a self-timed program cycle whose length in system clocks is a parameter. If the host drops select and raises it again while that cycle runs, the block reports busy or ready on the data output. The data output is modelled as a value plus an output-enable, with no tri-state pin.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, programming is disabled, and every word reads as 16'hFFFF.
- R2: After select rises, the decoder ignores DI bits of 0 taken on shift-clock rising edges until the first 1. That 1 is the start bit. The next two bits form the operation code, and the six bits after those form the address, most significant bit first.
- R3: Operation code 2'b10 reads a word. On the shift-clock rising edge that takes the last address bit, the output enable rises and data out shows a dummy 0. Each of the next 16 rising edges then presents one data bit, most significant first, and data out changes only on rising edges.
- R4: Operation code 2'b01 writes a word. It takes 16 data bits after the address, most significant first, and stores them at the address with no prior erase.
- R5: Code 2'b00 with address bits [5:4]=2'b00 disables programming. While programming is disabled, write, erase, erase-all and write-all leave the array unchanged.
- R6: Code 2'b00 with address bits [5:4]=2'b11 enables programming. The enable remains set across any number of later operations until a disable command or a reset.
- R7: Operation code 2'b11 sets the addressed word to 16'hFFFF.
- R8: Code 2'b00 with address bits [5:4]=2'b10 sets every word to 16'hFFFF. Address bits [5:4]=2'b01, followed by 16 data bits, writes that value to every word.
- R9: An accepted change starts a program cycle of PROG_CYCLES system clocks. If select falls and then rises again inside that cycle, the output enable goes high and data out shows 0 while the cycle runs, then shows 1 once it ends.
- R10: If select rises after the program cycle has ended, no status is shown and the output enable stays low.
- R11: The block ignores every bit of a frame opened while a program cycle runs.
- R12: The output enable is low whenever select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Chip select from the host, asynchronous |
| sclk_i | input | 1 | Serial shift clock, asynchronous and much slower than clk |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
The hardest case to reach is the busy/ready report. The host must finish a programming frame, drop select, and raise it again before the self-timed cycle expires, and it must then keep select high until the cycle ends so that the status changes from 0 to 1. The stimulus uses a long cycle and re-opens select within a few clocks after the last data bit. While in status mode it clocks a complete write frame, then reads the target word back to show that the frame had no effect. A separate re-open after the cycle has expired shows that no status appears. Random mixes of enable, disable, write, erase and read traffic are checked against a bench-side copy of the array and of the enable latch.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    // Frame decoder states
    typedef enum logic [2:0] {
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_STATUS,
        ST_DONE
    } frame_state_t;

    // Operation codes carried in the two bits after the start bit
    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    // Special sub-commands taken from the top two address bits
    localparam logic [1:0] SP_DISABLE = 2'b00;
    localparam logic [1:0] SP_WRALL   = 2'b01;
    localparam logic [1:0] SP_ERALL   = 2'b10;
    localparam logic [1:0] SP_ENABLE  = 2'b11;

endpackage

// File: rtl/pin_sync.sv
// pin_sync: two-flop synchronizer for a vector of asynchronous bus pins.
// Assumes each pin toggles far slower than clk; gives no bus coherency.
module pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the raw pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= raw_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/prog_timer.sv
// prog_timer: self-timed program cycle. A start pulse loads the counter.
// busy_o stays high for CYCLES clocks. Assumes start is never raised while busy.
module prog_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/word_store.sv
// word_store: register-based word array with one shared address.
// Reset fills every word with ones (erased). A whole-array write beats a
// single-word write. Reads are combinational.
module word_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic                     we_one_i,
    input  logic                     we_all_i,
    output logic [DATA_W-1:0]        rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Array update: reset to ones, whole-array or single-word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we_all_i) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= wdata_i;
        end else if (we_one_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/frame_decoder.sv
// frame_decoder: serial frame state machine. It takes bits on shift-clock
// rising edges, decodes the operation, keeps the programming-enable latch,
// drives read data and ready/busy status, and issues one-cycle write and
// timer-start pulses. Assumes cs, sk_rise and di come from synchronized pins.
module frame_decoder
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              cs_rise_i,
    input  logic              sk_rise_i,
    input  logic              di_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              we_one_o,
    output logic              we_all_o,
    output logic              prog_start_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              en_o,
    output logic              status_mode_o
);
    localparam int MAXW = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXW + 1);
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DATA_CNT  = CNT_W'(DATA_W);

    frame_state_t      state_q;
    logic [1:0]        op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic [ADDR_W-1:0] addr_next;
    logic [DATA_W-1:0] data_next;
    logic [1:0]        sub_cmd;

    // Next address and data words with the current bit shifted in
    assign addr_next = {addr_o[ADDR_W-2:0], di_i};
    assign data_next = {sh_q[DATA_W-2:0], di_i};
    assign sub_cmd   = addr_next[ADDR_W-1 -: 2];
    assign status_mode_o = (state_q == ST_STATUS);

    // Frame sequencing, enable latch, output driving and write pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_START;
            op_q         <= '0;
            addr_o       <= '0;
            cnt_q        <= '0;
            sh_q         <= '0;
            en_o         <= 1'b0;
            sdo_o        <= 1'b0;
            sdo_oe_o     <= 1'b0;
            wr_data_o    <= '0;
            we_one_o     <= 1'b0;
            we_all_o     <= 1'b0;
            prog_start_o <= 1'b0;
        end else begin
            we_one_o     <= 1'b0;
            we_all_o     <= 1'b0;
            prog_start_o <= 1'b0;
            if (!cs_i) begin
                state_q  <= ST_START;
                sdo_oe_o <= 1'b0;
                sdo_o    <= 1'b0;
                cnt_q    <= '0;
            end else if (cs_rise_i) begin
                cnt_q <= '0;
                if (busy_i) begin
                    state_q  <= ST_STATUS;
                    sdo_oe_o <= 1'b1;
                    sdo_o    <= 1'b0;
                end else begin
                    state_q <= ST_START;
                end
            end else if (state_q == ST_STATUS) begin
                sdo_o <= !busy_i;
            end else if (sk_rise_i) begin
                case (state_q)
                    ST_START: begin
                        if (di_i) begin
                            state_q <= ST_OPC;
                            cnt_q   <= '0;
                        end
                    end
                    ST_OPC: begin
                        op_q <= {op_q[0], di_i};
                        if (cnt_q == OPC_LAST) begin
                            state_q <= ST_ADDR;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_o <= addr_next;
                        if (cnt_q == ADDR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_DONE;
                            case (op_q)
                                OP_READ: begin
                                    state_q  <= ST_READ;
                                    sdo_oe_o <= 1'b1;
                                    sdo_o    <= 1'b0;
                                end
                                OP_WRITE: state_q <= ST_DATA;
                                OP_ERASE: begin
                                    if (en_o) begin
                                        wr_data_o    <= '1;
                                        we_one_o     <= 1'b1;
                                        prog_start_o <= 1'b1;
                                    end
                                end
                                default: begin
                                    case (sub_cmd)
                                        SP_ENABLE:  en_o <= 1'b1;
                                        SP_DISABLE: en_o <= 1'b0;
                                        SP_ERALL: begin
                                            if (en_o) begin
                                                wr_data_o    <= '1;
                                                we_all_o     <= 1'b1;
                                                prog_start_o <= 1'b1;
                                            end
                                        end
                                        default: state_q <= ST_DATA;
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        sh_q <= data_next;
                        if (cnt_q == DATA_LAST) begin
                            state_q <= ST_DONE;
                            if (en_o) begin
                                wr_data_o    <= data_next;
                                prog_start_o <= 1'b1;
                                if (op_q == OP_WRITE) we_one_o <= 1'b1;
                                else                  we_all_o <= 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (cnt_q == DATA_CNT) begin
                            sdo_oe_o <= 1'b0;
                            sdo_o    <= 1'b0;
                            state_q  <= ST_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == '0) begin
                                sdo_o <= rd_data_i[DATA_W-1];
                                sh_q  <= {rd_data_i[DATA_W-2:0], 1'b0};
                            end else begin
                                sdo_o <= sh_q[DATA_W-1];
                                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_eeprom_slave.sv
// serial_eeprom_slave: top of the three-wire serial EEPROM model.
// It synchronizes the bus pins, finds select and shift-clock rising edges,
// and connects the decoder, the word array and the program timer.
// Assumes the shift clock half period spans several system clocks.
module serial_eeprom_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [2:0]        pins_s;
    logic              cs_s, sk_s, di_s;
    logic              cs_d, sk_d;
    logic              cs_rise, sk_rise;
    logic              busy, prog_start, en_q, status_mode;
    logic              we_one, we_all;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    pin_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sel_i, sclk_i, sdi_i}),
        .sync_o (pins_s)
    );

    assign {cs_s, sk_s, di_s} = pins_s;

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d <= 1'b0;
            sk_d <= 1'b0;
        end else begin
            cs_d <= cs_s;
            sk_d <= sk_s;
        end
    end

    assign cs_rise = cs_s & ~cs_d;
    assign sk_rise = sk_s & ~sk_d;

    frame_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_i          (cs_s),
        .cs_rise_i     (cs_rise),
        .sk_rise_i     (sk_rise),
        .di_i          (di_s),
        .busy_i        (busy),
        .rd_data_i     (rd_data),
        .addr_o        (addr),
        .wr_data_o     (wr_data),
        .we_one_o      (we_one),
        .we_all_o      (we_all),
        .prog_start_o  (prog_start),
        .sdo_o         (sdo_o),
        .sdo_oe_o      (sdo_oe_o),
        .en_o          (en_q),
        .status_mode_o (status_mode)
    );

    word_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .wdata_i  (wr_data),
        .we_one_i (we_one),
        .we_all_i (we_all),
        .rdata_o  (rd_data)
    );

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy)
    );
endmodule

// File: rtl/serial_eeprom_checker.sv
// serial_eeprom_checker: temporal properties of the EEPROM model, bound to
// the top. Relates the output pins to select, the shift-clock edge, the
// program timer and the enable latch.
module serial_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic sel_i,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic sk_rise,
    input logic busy,
    input logic prog_start,
    input logic en_q,
    input logic status_mode
);
    logic [2:0] cs_low_cnt;

    // Count consecutive clocks with select low, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_low_cnt <= '0;
        else if (sel_i)
            cs_low_cnt <= '0;
        else if (cs_low_cnt != 3'd7)
            cs_low_cnt <= cs_low_cnt + 1'b1;
    end

    a_r12_oe_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low_cnt == 3'd7) |-> !sdo_oe_o);

    a_r5_cycle_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> en_q);

    a_r9_busy_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_mode && busy) |-> (sdo_oe_o && !sdo_o));

    a_r9_ready_shows_one: assert property (@(posedge clk) disable iff (!rst_n)
        (status_mode && $past(status_mode) && !busy && !$past(busy)) |-> sdo_o);

    a_r11_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !prog_start);

    a_r3_read_bits_on_sk_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && $past(sdo_oe_o) && !status_mode && (sdo_o != $past(sdo_o)))
            |-> $past(sk_rise));
endmodule

bind serial_eeprom_slave serial_eeprom_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .sk_rise     (sk_rise),
    .busy        (busy),
    .prog_start  (prog_start),
    .en_q        (en_q),
    .status_mode (status_mode)
);

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n, sel, sclk, sdi;
    logic sdo, sdo_oe;
    int   errs = 0;
    int   checks = 0;
    int   cycles = 0;
    bit   done = 1'b0;
    bit [15:0] ref_mem [64];
    bit        ref_en;

    always #2 clk = ~clk;

    serial_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            errs++;
            checks++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit d);
        sdi = d; tick(4);
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(4);
    endtask

    task automatic open_frame;
        sel = 1'b1; tick(6);
    endtask

    task automatic close_frame;
        sel = 1'b0; sdi = 1'b0; tick(6);
    endtask

    task automatic send_hdr(input bit [1:0] op, input bit [5:0] a);
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = 5; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic send_word(input bit [15:0] d);
        for (int i = 15; i >= 0; i--) pulse(d[i]);
    endtask

    // Bench reference of the array and enable latch
    function automatic void model_cmd(input bit [1:0] op, input bit [5:0] a, input bit [15:0] d);
        if (op == 2'b01 && ref_en) ref_mem[a] = d;
        else if (op == 2'b11 && ref_en) ref_mem[a] = 16'hFFFF;
        else if (op == 2'b00) begin
            case (a[5:4])
                2'b11: ref_en = 1'b1;
                2'b00: ref_en = 1'b0;
                2'b10: if (ref_en) for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
                default: if (ref_en) for (int i = 0; i < 64; i++) ref_mem[i] = d;
            endcase
        end
    endfunction

    function automatic bit [15:0] model_read(input bit [5:0] a);
        return ref_mem[a];
    endfunction

    function automatic bit needs_data(input bit [1:0] op, input bit [5:0] a);
        return (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
    endfunction

    task automatic run_cmd(input bit [1:0] op, input bit [5:0] a, input bit [15:0] d);
        open_frame;
        send_hdr(op, a);
        if (needs_data(op, a)) send_word(d);
        close_frame;
        model_cmd(op, a, d);
        tick(PROG + 20);
    endtask

    task automatic check_read(input string tag, input bit [5:0] a, input int lead_zeros);
        logic [15:0] v;
        logic dummy, oe_ok;
        open_frame;
        for (int i = 0; i < lead_zeros; i++) pulse(1'b0);
        send_hdr(2'b10, a);
        dummy = sdo;
        oe_ok = sdo_oe;
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0);
            v[i] = sdo;
            oe_ok = oe_ok & sdo_oe;
        end
        close_frame;
        chk({tag, " R3 dummy bit"}, {15'd0, dummy}, 16'd0);
        chk({tag, " R3 output enable"}, {15'd0, oe_ok}, 16'd1);
        chk({tag, " data"}, v, model_read(a));
    endtask

    initial begin
        int unsigned seed_v;
        rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
        for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
        ref_en = 1'b0;
        seed_v = $urandom(32'd4321);
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 and R12: reset state
        chk("R1 oe after reset", {15'd0, sdo_oe}, 16'd0);
        check_read("R1 erased word 5", 6'd5, 0);
        chk("R12 oe low after frame", {15'd0, sdo_oe}, 16'd0);

        // R5: write while disabled
        run_cmd(2'b01, 6'd3, 16'h1357);
        check_read("R5 write ignored disabled", 6'd3, 0);

        // R6, R4, R9, R11: enable, write, busy status, frame during busy
        run_cmd(2'b00, 6'b110000, 16'h0);
        open_frame;
        send_hdr(2'b01, 6'd3);
        send_word(16'hA5C3);
        sel = 1'b0; tick(4);
        model_cmd(2'b01, 6'd3, 16'hA5C3);
        sel = 1'b1; tick(6);
        chk("R9 status oe during cycle", {15'd0, sdo_oe}, 16'd1);
        chk("R9 busy shows 0", {15'd0, sdo}, 16'd0);
        send_hdr(2'b01, 6'd3);
        send_word(16'h0000);
        chk("R11 still busy after ignored frame", {15'd0, sdo}, 16'd0);
        tick(PROG);
        chk("R9 ready shows 1", {15'd0, sdo}, 16'd1);
        close_frame;
        check_read("R4 R11 write kept", 6'd3, 0);

        // R10: select rises after cycle ended
        open_frame;
        tick(10);
        chk("R10 no status after cycle", {15'd0, sdo_oe}, 16'd0);
        close_frame;

        // R2: leading zeros before start bit
        check_read("R2 leading zeros", 6'd3, 3);

        // R7: erase one word
        run_cmd(2'b11, 6'd3, 16'h0);
        check_read("R7 erase word", 6'd3, 0);

        // Random traffic against the reference model (R4 R5 R6 R7)
        for (int n = 0; n < 40; n++) begin
            int unsigned r;
            bit [5:0] a;
            bit [15:0] d;
            r = $urandom_range(0, 9);
            a = 6'($urandom_range(0, 63));
            d = 16'($urandom());
            if (r == 0)      run_cmd(2'b00, 6'b110000, 16'h0);
            else if (r == 1) run_cmd(2'b00, 6'b000000, 16'h0);
            else if (r <= 4) run_cmd(2'b01, a, d);
            else if (r == 5) run_cmd(2'b11, a, d);
            else             check_read("R6 random read", a, 0);
        end

        // R8: write-all then erase-all with enable set
        run_cmd(2'b00, 6'b110000, 16'h0);
        run_cmd(2'b00, 6'b010000, 16'h1234);
        check_read("R8 write-all word 0", 6'd0, 0);
        check_read("R8 write-all word 63", 6'd63, 0);
        run_cmd(2'b00, 6'b100000, 16'h0);
        check_read("R8 erase-all word 17", 6'd17, 0);

        // R5: erase-all and write-all ignored after disable
        run_cmd(2'b01, 6'd9, 16'h00F0);
        run_cmd(2'b00, 6'b000000, 16'h0);
        run_cmd(2'b00, 6'b100000, 16'h0);
        run_cmd(2'b00, 6'b010000, 16'hBEEF);
        check_read("R5 array kept after disable", 6'd9, 0);
        chk("R12 oe low at end", {15'd0, sdo_oe}, 16'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule